// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Manager

This block holds the descriptor table for the transmit and receive paths of a 10/100 Ethernet MAC, and it steps through that table in hardware. Software reads and writes descriptors through a word-wide register port. Each descriptor takes two 32-bit words in the register space: a status/control word, followed by a buffer address word. A separate configuration write sets how many table entries belong to transmit. The receive ring takes the entries that follow.

On the transmit side the block presents the current descriptor to a frame engine while its ready bit is set. It shows the buffer address, the length, and the per-frame CRC and padding requests. When the engine reports completion, the block writes the completion status back into the descriptor and moves on. On the receive side it presents the current empty descriptor. When the engine reports a received length and error flags, the block writes them back and moves on. If no empty descriptor is available, the frame is dropped and a busy event is raised. Each ring returns to its first entry after a descriptor with the wrap bit set, or after its last table entry. Interrupt events are one-cycle pulses.

Top module: `eth_bd_ring`

## Requirements
- R1: After a synchronous reset, all table words are zero. The transmit pointer is 0, the receive pointer equals the default transmit count (64), both avail outputs are low and no event is raised.
- R2: Byte address 0x400+8*i selects the status word of entry i, and 0x400+8*i+4 selects its buffer address word. Writes outside 0x400..0x400+8*NUM_DESC-1 are ignored, and reads there return 0.
- R3: A transmit-count write stores min(value, NUM_DESC). In the next cycle the transmit pointer is 0 and the receive pointer equals the stored count.
- R4: tx_avail is high when the transmit ring is non-empty and status bit 15 (ready) of the current entry is set. tx_buf_addr is the entry's address word, tx_len is bits [31:16], and tx_crc is bit 11. tx_pad is bit 12 AND length < 64.
- R5: A transmit completion clears bit 15 and writes tx_result into bits [8:0]: 8 underrun, [7:4] retries, 3 retry limit, 2 late collision, 1 deferred, 0 carrier lost. All other bits are kept, and the pointer advances.
- R6: The transmit pointer returns to 0 after an entry with bit 13 (wrap) set, or after entry count-1.
- R7: rx_avail is high when the receive ring is non-empty and bit 15 (empty) of the current entry is set. rx_buf_addr is that entry's address word.
- R8: A receive completion writes rx_len into bits [31:16] and clears bit 15. It writes rx_flags into bits [8:0]: 8 control frame, 7 address miss, 6 overrun, 5 invalid symbol, 4 dribble nibble, 3 too long, 2 too short, 1 CRC error, 0 late collision. It keeps bits [14:9] and advances. The receive pointer returns to the first receive entry after bit 13 is set or after entry NUM_DESC-1.
- R9: A receive completion while rx_avail is low changes no descriptor and does not move the pointer. It raises ev_rx_busy one cycle later.
- R10: One cycle after a completion whose descriptor has bit 14 set, exactly one event of that ring pulses. The error event pulses when any error flag was written: transmit bits 8, 3, 2, 0, or receive bits 6, 5, 3, 2, 1, 0. Otherwise the done event pulses. With bit 14 clear, no event pulses.
- R11: tx_done while tx_avail is low is ignored.
- R12: Without a completion or a count write, the ring pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 11 | Byte address into the register space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| txnum_wr | input | 1 | Transmit-count write strobe |
| txnum_wdata | input | 8 | Requested number of transmit entries |
| tx_avail | output | 1 | Current transmit descriptor is ready |
| tx_buf_addr | output | 32 | Buffer address of the current transmit descriptor |
| tx_len | output | 16 | Frame length of the current transmit descriptor |
| tx_pad | output | 1 | Pad request for a short frame |
| tx_crc | output | 1 | CRC append request |
| tx_done | input | 1 | Engine finished the current transmit descriptor |
| tx_result | input | 9 | Transmit completion status for bits [8:0] |
| rx_avail | output | 1 | Current receive descriptor is empty |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |
| rx_done | input | 1 | Engine delivered a received frame |
| rx_len | input | 16 | Received length including CRC |
| rx_flags | input | 9 | Receive flags for bits [8:0] |
| ev_tx_done | output | 1 | Transmit done event pulse |
| ev_tx_err | output | 1 | Transmit error event pulse |
| ev_rx_done | output | 1 | Receive done event pulse |
| ev_rx_err | output | 1 | Receive error event pulse |
| ev_rx_busy | output | 1 | Receive frame dropped event pulse |
| tx_cur | output | 7 | Current transmit entry index |
| rx_cur | output | 8 | Current receive entry index |

## Verification
The assertions check on every cycle that at most one event per ring fires and that each event has a matching completion or drop in the cycle before. They also check that the pointers hold steady unless a completion or a count write occurs, and that a count write sends the transmit pointer to zero. Only the bench scenarios can show the contents of the written-back status words, the wrap on a bit versus the wrap on the last entry, the clamping of the count, the choice between error and done for particular flags, and the fact that writes outside the table are ignored.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;

    // Status/control word layout shared by both rings
    typedef struct packed {
        logic [15:0] len;
        logic        own;     // tx: ready, rx: empty
        logic        irq;
        logic        wrap;
        logic        pad;
        logic        crc;
        logic [1:0]  rsv;
        logic [8:0]  info;
    } bd_stat_t;

    typedef struct packed {
        logic       underrun;
        logic [3:0] retries;
        logic       retry_lim;
        logic       late_col;
        logic       deferred;
        logic       carrier_lost;
    } tx_res_t;

    typedef struct packed {
        logic ctrl_frame;
        logic addr_miss;
        logic overrun;
        logic bad_symbol;
        logic dribble;
        logic too_long;
        logic too_short;
        logic crc_bad;
        logic late_col;
    } rx_flg_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_DONE = 2'd1,
        EV_ERR  = 2'd2,
        EV_BUSY = 2'd3
    } ring_ev_t;

    function automatic logic tx_has_error(tx_res_t r);
        return r.underrun | r.retry_lim | r.late_col | r.carrier_lost;
    endfunction

    function automatic logic rx_has_error(rx_flg_t f);
        return f.overrun | f.bad_symbol | f.too_long | f.too_short | f.crc_bad | f.late_col;
    endfunction

endpackage

// File: rtl/bd_table.sv
module bd_table
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_hi,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic [IDX_W-1:0] tx_idx,
    output bd_stat_t         tx_stat,
    output logic [31:0]      tx_buf,
    input  logic             tx_wb_en,
    input  bd_stat_t         tx_wb_stat,
    input  logic [IDX_W-1:0] rx_idx,
    output bd_stat_t         rx_stat,
    output logic [31:0]      rx_buf,
    input  logic             rx_wb_en,
    input  bd_stat_t         rx_wb_stat
);

    logic [31:0] stat_q [NUM_DESC];
    logic [31:0] buf_q  [NUM_DESC];

    // Engine write-back takes priority over a software write to the same status word
    for (genvar e = 0; e < NUM_DESC; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[e] <= '0;
                buf_q[e]  <= '0;
            end else begin
                if (tx_wb_en && tx_idx == IDX_W'(e))
                    stat_q[e] <= tx_wb_stat;
                else if (rx_wb_en && rx_idx == IDX_W'(e))
                    stat_q[e] <= rx_wb_stat;
                else if (sw_we && !sw_hi && sw_idx == IDX_W'(e))
                    stat_q[e] <= sw_wdata;
                if (sw_we && sw_hi && sw_idx == IDX_W'(e))
                    buf_q[e] <= sw_wdata;
            end
        end
    end

    always_comb begin
        sw_rdata = sw_hi ? buf_q[sw_idx] : stat_q[sw_idx];
        tx_stat  = bd_stat_t'(stat_q[tx_idx]);
        tx_buf   = buf_q[tx_idx];
        rx_stat  = bd_stat_t'(stat_q[rx_idx]);
        rx_buf   = buf_q[rx_idx];
    end

endmodule

// File: rtl/bd_tx_ctrl.sv
module bd_tx_ctrl
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC  = 128,
    parameter int IDX_W     = $clog2(NUM_DESC),
    parameter int CNT_W     = $clog2(NUM_DESC + 1),
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_we,
    input  bd_stat_t         cur,
    input  logic             done,
    input  tx_res_t          res,
    output logic [IDX_W-1:0] ptr,
    output logic             avail,
    output logic             pad_req,
    output logic             wb_en,
    output bd_stat_t         wb_stat,
    output ring_ev_t         ev
);

    logic [IDX_W-1:0] ptr_q;
    ring_ev_t         ev_q;
    logic             has_ring;
    logic             last;

    always_comb begin
        has_ring = (cnt != '0);
        avail    = has_ring && cur.own;
        wb_en    = done && avail;
        pad_req  = cur.pad && (cur.len < 16'(MIN_FRAME));
        last     = cur.wrap || (CNT_W'(ptr_q) == cnt - CNT_W'(1));
        wb_stat      = cur;
        wb_stat.own  = 1'b0;
        wb_stat.info = res;
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_we)
            ptr_q <= '0;
        else if (wb_en)
            ptr_q <= last ? '0 : ptr_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ev_q <= EV_NONE;
        else if (wb_en && cur.irq)
            ev_q <= tx_has_error(res) ? EV_ERR : EV_DONE;
        else
            ev_q <= EV_NONE;
    end

    assign ptr = ptr_q;
    assign ev  = ev_q;

endmodule

// File: rtl/bd_rx_ctrl.sv
module bd_rx_ctrl
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = $clog2(NUM_DESC),
    parameter int CNT_W    = $clog2(NUM_DESC + 1),
    parameter int RST_CNT  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_new,
    input  logic             cnt_we,
    input  bd_stat_t         cur,
    input  logic             done,
    input  logic [15:0]      len_in,
    input  rx_flg_t          flags,
    output logic [CNT_W-1:0] ptr,
    output logic [IDX_W-1:0] idx,
    output logic             avail,
    output logic             wb_en,
    output bd_stat_t         wb_stat,
    output ring_ev_t         ev
);

    logic [CNT_W-1:0] ptr_q;
    ring_ev_t         ev_q;
    logic             has_ring;
    logic             last;
    logic             drop;

    always_comb begin
        has_ring = (cnt < CNT_W'(NUM_DESC));
        idx      = has_ring ? ptr_q[IDX_W-1:0] : '0;
        avail    = has_ring && cur.own;
        wb_en    = done && avail;
        drop     = done && !avail;
        last     = cur.wrap || (ptr_q == CNT_W'(NUM_DESC - 1));
        wb_stat      = cur;
        wb_stat.own  = 1'b0;
        wb_stat.len  = len_in;
        wb_stat.info = flags;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= CNT_W'(RST_CNT);
        else if (cnt_we)
            ptr_q <= cnt_new;
        else if (wb_en)
            ptr_q <= last ? cnt : ptr_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ev_q <= EV_NONE;
        else if (drop)
            ev_q <= EV_BUSY;
        else if (wb_en && cur.irq)
            ev_q <= rx_has_error(flags) ? EV_ERR : EV_DONE;
        else
            ev_q <= EV_NONE;
    end

    assign ptr = ptr_q;
    assign ev  = ev_q;

endmodule

// File: rtl/eth_bd_ring.sv
module eth_bd_ring
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC   = 128,
    parameter int ADDR_W     = 11,
    parameter int DESC_BASE  = 32'h400,
    parameter int TXNUM_W    = 8,
    parameter int TXNUM_RST  = 64,
    parameter int MIN_FRAME  = 64,
    localparam int IDX_W     = $clog2(NUM_DESC),
    localparam int CNT_W     = $clog2(NUM_DESC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txnum_wr,
    input  logic [TXNUM_W-1:0] txnum_wdata,
    output logic              tx_avail,
    output logic [31:0]       tx_buf_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_result,
    output logic              rx_avail,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_flags,
    output logic              ev_tx_done,
    output logic              ev_tx_err,
    output logic              ev_rx_done,
    output logic              ev_rx_err,
    output logic              ev_rx_busy,
    output logic [IDX_W-1:0]  tx_cur,
    output logic [CNT_W-1:0]  rx_cur
);

    localparam int RST_CNT  = (TXNUM_RST > NUM_DESC) ? NUM_DESC : TXNUM_RST;
    localparam int DESC_END = DESC_BASE + NUM_DESC * 8;

    // Transmit count register with clamp
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_new;

    always_comb begin
        if (int'(txnum_wdata) > NUM_DESC)
            cnt_new = CNT_W'(NUM_DESC);
        else
            cnt_new = CNT_W'(txnum_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_CNT);
        else if (txnum_wr)
            cnt_q <= cnt_new;
    end

    // Software address decode
    logic [31:0]      addr_ext;
    logic [31:0]      off;
    logic             in_range;
    logic [IDX_W-1:0] sw_idx;
    logic             sw_hi;
    logic [31:0]      sw_rdata;
    logic             unused_off;

    always_comb begin
        addr_ext = 32'(reg_addr);
        in_range = (addr_ext >= 32'(DESC_BASE)) && (addr_ext < 32'(DESC_END));
        off      = addr_ext - 32'(DESC_BASE);
        sw_idx   = off[IDX_W+2:3];
        sw_hi    = off[2];
        reg_rdata = in_range ? sw_rdata : '0;
    end

    assign unused_off = ^{off[31:IDX_W+3], off[1:0]};

    // Interconnect
    bd_stat_t         tx_stat, tx_wb_stat, rx_stat, rx_wb_stat;
    logic [31:0]      tx_buf, rx_buf;
    logic             tx_wb_en, rx_wb_en;
    logic [IDX_W-1:0] tx_ptr, rx_idx;
    ring_ev_t         tx_ev, rx_ev;

    bd_table #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .sw_we      (reg_wr && in_range),
        .sw_idx     (sw_idx),
        .sw_hi      (sw_hi),
        .sw_wdata   (reg_wdata),
        .sw_rdata   (sw_rdata),
        .tx_idx     (tx_ptr),
        .tx_stat    (tx_stat),
        .tx_buf     (tx_buf),
        .tx_wb_en   (tx_wb_en),
        .tx_wb_stat (tx_wb_stat),
        .rx_idx     (rx_idx),
        .rx_stat    (rx_stat),
        .rx_buf     (rx_buf),
        .rx_wb_en   (rx_wb_en),
        .rx_wb_stat (rx_wb_stat)
    );

    bd_tx_ctrl #(
        .NUM_DESC  (NUM_DESC),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .MIN_FRAME (MIN_FRAME)
    ) u_tx (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_q),
        .cnt_we  (txnum_wr),
        .cur     (tx_stat),
        .done    (tx_done),
        .res     (tx_res_t'(tx_result)),
        .ptr     (tx_ptr),
        .avail   (tx_avail),
        .pad_req (tx_pad),
        .wb_en   (tx_wb_en),
        .wb_stat (tx_wb_stat),
        .ev      (tx_ev)
    );

    bd_rx_ctrl #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W),
        .RST_CNT  (RST_CNT)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_q),
        .cnt_new (cnt_new),
        .cnt_we  (txnum_wr),
        .cur     (rx_stat),
        .done    (rx_done),
        .len_in  (rx_len),
        .flags   (rx_flg_t'(rx_flags)),
        .ptr     (rx_cur),
        .idx     (rx_idx),
        .avail   (rx_avail),
        .wb_en   (rx_wb_en),
        .wb_stat (rx_wb_stat),
        .ev      (rx_ev)
    );

    always_comb begin
        tx_buf_addr = tx_buf;
        tx_len      = tx_stat.len;
        tx_crc      = tx_stat.crc;
        rx_buf_addr = rx_buf;
        tx_cur      = tx_ptr;
        ev_tx_done  = (tx_ev == EV_DONE);
        ev_tx_err   = (tx_ev == EV_ERR);
        ev_rx_done  = (rx_ev == EV_DONE);
        ev_rx_err   = (rx_ev == EV_ERR);
        ev_rx_busy  = (rx_ev == EV_BUSY);
    end

endmodule

// File: rtl/eth_bd_ring_chk.sv
module eth_bd_ring_chk #(
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             txnum_wr,
    input logic             tx_done,
    input logic             tx_avail,
    input logic             rx_done,
    input logic             rx_avail,
    input logic             ev_tx_done,
    input logic             ev_tx_err,
    input logic             ev_rx_done,
    input logic             ev_rx_err,
    input logic             ev_rx_busy,
    input logic [IDX_W-1:0] tx_cur,
    input logic [CNT_W-1:0] rx_cur
);

    assert_tx_ev_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_tx_done, ev_tx_err}));

    assert_rx_ev_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_rx_done, ev_rx_err, ev_rx_busy}));

    assert_tx_ev_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_done || ev_tx_err) |-> $past(tx_done && tx_avail));

    assert_rx_ev_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_done || ev_rx_err) |-> $past(rx_done && rx_avail));

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (rst)
        ev_rx_busy |-> $past(rx_done && !rx_avail));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_avail && !txnum_wr) |=> $stable(rx_cur));

    assert_cnt_wr_R3: assert property (@(posedge clk) disable iff (rst)
        txnum_wr |=> (tx_cur == '0));

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!txnum_wr && !(tx_done && tx_avail)) |=> $stable(tx_cur));

    assert_rx_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!txnum_wr && !(rx_done && rx_avail)) |=> $stable(rx_cur));

endmodule

bind eth_bd_ring eth_bd_ring_chk #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txnum_wr   (txnum_wr),
    .tx_done    (tx_done),
    .tx_avail   (tx_avail),
    .rx_done    (rx_done),
    .rx_avail   (rx_avail),
    .ev_tx_done (ev_tx_done),
    .ev_tx_err  (ev_tx_err),
    .ev_rx_done (ev_rx_done),
    .ev_rx_err  (ev_rx_err),
    .ev_rx_busy (ev_rx_busy),
    .tx_cur     (tx_cur),
    .rx_cur     (rx_cur)
);

// File: tb/eth_bd_ring_bench.sv
`timescale 1ns/1ps
module eth_bd_ring_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [10:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        txnum_wr;
    logic [7:0]  txnum_wdata;
    logic        tx_avail;
    logic [31:0] tx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_pad, tx_crc, tx_done;
    logic [8:0]  tx_result;
    logic        rx_avail;
    logic [31:0] rx_buf_addr;
    logic        rx_done;
    logic [15:0] rx_len;
    logic [8:0]  rx_flags;
    logic        ev_tx_done, ev_tx_err, ev_rx_done, ev_rx_err, ev_rx_busy;
    logic [6:0]  tx_cur;
    logic [7:0]  rx_cur;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Expected event kinds: 1 tx done, 2 tx err, 3 rx done, 4 rx err, 5 rx busy
    int exp_q[$];

    always #2.5 clk = ~clk;

    eth_bd_ring u_eth_bd_ring (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txnum_wr(txnum_wr), .txnum_wdata(txnum_wdata),
        .tx_avail(tx_avail), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_result(tx_result),
        .rx_avail(rx_avail), .rx_buf_addr(rx_buf_addr), .rx_done(rx_done),
        .rx_len(rx_len), .rx_flags(rx_flags),
        .ev_tx_done(ev_tx_done), .ev_tx_err(ev_tx_err), .ev_rx_done(ev_rx_done),
        .ev_rx_err(ev_rx_err), .ev_rx_busy(ev_rx_busy),
        .tx_cur(tx_cur), .rx_cur(rx_cur)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pop_event(string req, int kind);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: actual event %0d expected none", req, kind);
        end else begin
            int e = exp_q.pop_front();
            if (e != kind) begin
                errors++;
                $display("FAIL %s: actual event %0d expected %0d", req, kind, e);
            end
        end
    endtask

    // Monitor: pops expected events as the design raises them
    always @(negedge clk) begin
        if (!rst) begin
            if (ev_tx_done) pop_event("R10", 1);
            if (ev_tx_err)  pop_event("R10", 2);
            if (ev_rx_done) pop_event("R10", 3);
            if (ev_rx_err)  pop_event("R10", 4);
            if (ev_rx_busy) pop_event("R9", 5);
        end
    end

    task automatic reg_write(logic [10:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(string req, logic [10:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic set_count(logic [7:0] v);
        @(negedge clk);
        txnum_wr = 1'b1; txnum_wdata = v;
        @(negedge clk);
        txnum_wr = 1'b0;
        #1;
    endtask

    // Driver: pushes the expected event, then pulses the completion
    task automatic tx_complete(logic [8:0] res, int exp_kind);
        if (exp_kind != 0) exp_q.push_back(exp_kind);
        @(negedge clk);
        tx_done = 1'b1; tx_result = res;
        @(negedge clk);
        tx_done = 1'b0;
        #1;
    endtask

    task automatic rx_complete(logic [15:0] len, logic [8:0] flg, int exp_kind);
        if (exp_kind != 0) exp_q.push_back(exp_kind);
        @(negedge clk);
        rx_done = 1'b1; rx_len = len; rx_flags = flg;
        @(negedge clk);
        rx_done = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        txnum_wr = 0; txnum_wdata = '0; tx_done = 0; tx_result = '0;
        rx_done = 0; rx_len = '0; rx_flags = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        chk("R1 tx_cur", 32'(tx_cur), 0);
        chk("R1 rx_cur", 32'(rx_cur), 64);
        chk("R1 avail", {30'd0, tx_avail, rx_avail}, 0);
        chk("R1 events", {27'd0, ev_tx_done, ev_tx_err, ev_rx_done, ev_rx_err, ev_rx_busy}, 0);
        reg_check("R1 table", 11'h400, 32'h0);

        // R3 count write and clamp
        set_count(8'd4);
        chk("R3 tx_cur", 32'(tx_cur), 0);
        chk("R3 rx_cur", 32'(rx_cur), 4);
        set_count(8'd200);
        chk("R3 clamp", 32'(rx_cur), 128);
        chk("R7 no rx ring", 32'(rx_avail), 0);
        rx_complete(16'd60, 9'h0, 5);
        chk("R9 ptr held", 32'(rx_cur), 128);
        set_count(8'd4);

        // R2/R4 transmit descriptors
        reg_write(11'h400, 32'h0064_D800);
        reg_write(11'h404, 32'h0000_1000);
        reg_write(11'h408, 32'h0028_D000);
        reg_write(11'h40C, 32'h0000_2000);
        reg_write(11'h410, 32'h0050_A000);
        reg_write(11'h414, 32'h0000_2500);
        reg_check("R2 addr word", 11'h404, 32'h0000_1000);
        chk("R4 avail", 32'(tx_avail), 1);
        chk("R4 addr", tx_buf_addr, 32'h1000);
        chk("R4 len", 32'(tx_len), 100);
        chk("R4 pad long frame", 32'(tx_pad), 0);
        chk("R4 crc", 32'(tx_crc), 1);

        // R5 completion with retries
        tx_complete(9'h020, 1);
        reg_check("R5 writeback", 11'h400, 32'h0064_5820);
        chk("R5 advance", 32'(tx_cur), 1);
        chk("R4 addr next", tx_buf_addr, 32'h2000);
        chk("R4 pad short frame", 32'(tx_pad), 1);
        chk("R4 crc off", 32'(tx_crc), 0);

        // R10 underrun gives error event
        tx_complete(9'h100, 2);
        reg_check("R5 underrun writeback", 11'h408, 32'h0028_5100);
        chk("R5 advance 2", 32'(tx_cur), 2);

        // R6 wrap bit, no irq enable gives no event
        tx_complete(9'h002, 0);
        reg_check("R10 no irq writeback", 11'h410, 32'h0050_2002);
        chk("R6 wrap bit", 32'(tx_cur), 0);
        chk("R4 not ready", 32'(tx_avail), 0);

        // R11 completion while not ready
        tx_complete(9'h1FF, 0);
        chk("R11 ptr", 32'(tx_cur), 0);
        reg_check("R11 desc", 11'h400, 32'h0064_5820);

        // R6 wrap on last entry without wrap bit
        set_count(8'd2);
        chk("R3 rx base", 32'(rx_cur), 2);
        reg_write(11'h400, 32'h0064_C000);
        reg_write(11'h408, 32'h0064_C000);
        tx_complete(9'h000, 1);
        chk("R6 step", 32'(tx_cur), 1);
        tx_complete(9'h000, 1);
        chk("R6 last entry", 32'(tx_cur), 0);

        // R7/R8 receive
        reg_write(11'h410, 32'h0000_C000);
        reg_write(11'h414, 32'h0000_3000);
        reg_write(11'h418, 32'h0000_E000);
        reg_write(11'h41C, 32'h0000_4000);
        chk("R7 avail", 32'(rx_avail), 1);
        chk("R7 addr", rx_buf_addr, 32'h3000);
        rx_complete(16'd68, 9'h000, 3);
        reg_check("R8 writeback", 11'h410, 32'h0044_4000);
        chk("R8 advance", 32'(rx_cur), 3);
        chk("R7 addr next", rx_buf_addr, 32'h4000);
        rx_complete(16'd70, 9'h002, 4);
        reg_check("R8 crc error writeback", 11'h418, 32'h0046_6002);
        chk("R8 wrap bit", 32'(rx_cur), 2);

        // R9 drop on full descriptor
        chk("R7 full", 32'(rx_avail), 0);
        rx_complete(16'd99, 9'h000, 5);
        chk("R9 ptr", 32'(rx_cur), 2);
        reg_check("R9 desc unchanged", 11'h410, 32'h0044_4000);

        // R10 dribble nibble alone is not an error
        reg_write(11'h410, 32'h0000_C000);
        rx_complete(16'd64, 9'h010, 3);
        reg_check("R10 dribble", 11'h410, 32'h0040_4010);

        // R8 wrap at last table entry
        set_count(8'd126);
        chk("R3 rx base 126", 32'(rx_cur), 126);
        reg_write(11'h7F0, 32'h0000_C000);
        reg_write(11'h7F8, 32'h0000_C000);
        rx_complete(16'd60, 9'h000, 3);
        chk("R8 step", 32'(rx_cur), 127);
        rx_complete(16'd60, 9'h000, 3);
        chk("R8 table end", 32'(rx_cur), 126);

        // R2 writes outside table ignored
        reg_write(11'h010, 32'hFFFF_FFFF);
        reg_check("R2 outside read", 11'h010, 32'h0);
        reg_check("R2 table intact", 11'h400, 32'h0064_4000);

        repeat (4) @(negedge clk);
        chk("R10 all events seen", 32'(exp_q.size()), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule